// File: doc/BRIEF.md
# Serial User-Flash Access Controller

This block lets ordinary user logic read, program and sector-erase a small embedded flash macro whose only access path is a pair of serial shift registers (one for the address, one for the data word) plus level strobes that start a program or an erase. The host side is a single-command valid/ready port carrying an operation code, a parallel address and a parallel write word. Each accepted command ends with a one-cycle response strobe that carries an error flag and, for reads, the word fetched from the array.

On the flash side the controller creates every shift clock itself, one bit per pulse and MSB first. It switches the data register between "load from array" and "shift" with a select line, pulses the program or erase strobe, and follows the macro's busy flag. No register clock and no strobe is issued while that flag is high. A separate reprogramming-in-progress flag from the macro overrides everything. While it is high, the controller quiets all flash-side clocks and strobes and closes the current command with an error. The oscillator enable is raised while a command is in flight, or held on permanently by a parameter.

Top module: `ufm_serial_ctrl`

## Requirements
- R1: `cmd_ready` is high only while the controller is idle. Once a command is taken (`cmd_valid` and `cmd_ready` high at a clock edge), `cmd_ready` stays low through the response cycle and returns high on the cycle after `rsp_valid`.
- R2: The address is sent MSB first as exactly AW rising edges of `fl_addr_clk`. `fl_addr_sdi` is set up one cycle before each rising edge and does not change on that edge.
- R3: A read (op code 0) gives one `fl_data_clk` pulse with `fl_data_sel` low, which loads the word. It then samples `fl_data_sdo` DW times, MSB first, with a `fl_data_clk` pulse and `fl_data_sel` high after each sample. The response has `rsp_err` = 0 and `rsp_rdata` equal to the stored word.
- R4: A write (op code 1) shifts the address, then DW data bits MSB first on `fl_data_sdi` with `fl_data_sel` high. It then raises `fl_prog` for one cycle and responds only after `fl_busy` has been seen high and then low again. `rsp_err` = 0 and `rsp_rdata` = 0.
- R5: An erase (op code 2) shifts the address, whose MSB picks the sector. It then raises `fl_erase` for one cycle and waits for `fl_busy` to rise and fall before responding with `rsp_err` = 0.
- R6: No rising edge of `fl_addr_clk` or `fl_data_clk`, and no rising edge of `fl_prog` or `fl_erase`, follows a clock edge at which `fl_busy` was high. A command delayed this way still completes with correct data.
- R7: Whenever `fl_isp_busy` was high at the previous clock edge, `fl_addr_clk`, `fl_data_clk`, `fl_prog` and `fl_erase` are all low. This holds whether the flag was already high when the command arrived or rose during it. That command ends with `rsp_err` = 1 and `rsp_rdata` = 0, and an aborted write leaves the array unchanged.
- R8: With OSC_KEEP_ON = 0, `fl_osc_en` is high from the cycle after acceptance through the response cycle and low while idle. With OSC_KEEP_ON = 1 it is always high.
- R9: During and right after reset, `cmd_ready` is high and `rsp_valid`, every flash clock and every strobe are low.
- R10: `fl_prog` and `fl_erase` are never high in two consecutive cycles. At most one of `fl_prog`, `fl_erase`, `fl_addr_clk` and `fl_data_clk` is high in any cycle.
- R11: Op code 3 is rejected. The controller responds with `rsp_err` = 1 and gives no flash clock or strobe at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| cmd_op | input | 2 | 0 read, 1 write, 2 sector erase, 3 rejected |
| cmd_addr | input | AW | Word address; MSB selects the erase sector |
| cmd_wdata | input | DW | Word to program |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Command aborted or rejected |
| rsp_rdata | output | DW | Word read from the array (zero otherwise) |
| fl_addr_clk | output | 1 | Address register shift clock |
| fl_addr_sdi | output | 1 | Address serial data |
| fl_data_clk | output | 1 | Data register clock |
| fl_data_sdi | output | 1 | Data register serial input |
| fl_data_sel | output | 1 | Data register mode: 1 shift, 0 load from array |
| fl_data_sdo | input | 1 | Data register serial output |
| fl_prog | output | 1 | Program strobe |
| fl_erase | output | 1 | Sector erase strobe |
| fl_osc_en | output | 1 | Flash oscillator enable |
| fl_busy | input | 1 | Program or erase in progress |
| fl_isp_busy | input | 1 | In-system reprogramming in progress |

## Verification
The bench builds the controller with its default widths: a 9-bit address, a 16-bit word and OSC_KEEP_ON at 0. These widths let a behavioural array stand-in hold every location, so both erase sectors can be cleared and checked in full. The stand-in's program and erase busy time is kept short. An extra busy source lets the bench hold the interlock in the middle of an address or data shift. The reprogramming flag is raised both before a command arrives and partway through a write's data shift, so both abort paths are reached.

// File: rtl/ufm_ctrl_pkg.sv
package ufm_ctrl_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } ufm_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ARM,
    S_ADDR,
    S_LOAD,
    S_RDOUT,
    S_WDATA,
    S_STROBE,
    S_WAIT_HI,
    S_WAIT_LO,
    S_FIN
  } seq_state_e;

  // True for the index of the final bit of a field of the given width.
  function automatic logic last_bit(input int unsigned idx, input int unsigned width);
    return idx == width - 1;
  endfunction

  function automatic logic op_known(input logic [1:0] code);
    return code != OP_RSVD;
  endfunction

  // Step that follows the address shift for each operation.
  function automatic seq_state_e after_addr(input ufm_op_e op);
    case (op)
      OP_READ:  return S_LOAD;
      OP_WRITE: return S_WDATA;
      default:  return S_STROBE;
    endcase
  endfunction

endpackage

// File: rtl/ufm_piso.sv
module ufm_piso #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         msb
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= {q[W-2:0], 1'b0};
  end

  assign msb = q[W-1];
endmodule

// File: rtl/ufm_sipo.sv
module ufm_sipo #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clear) q <= '0;
    else if (step)  q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/ufm_ctrl_seq.sv
module ufm_ctrl_seq
  import ufm_ctrl_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       fl_busy,
  input  logic       fl_isp_busy,
  input  logic       addr_msb,
  input  logic       data_msb,
  output logic       cmd_ready,
  output logic       rsp_valid,
  output logic       rsp_err,
  output logic       accept_evt,
  output logic       abort_evt,
  output logic       addr_step,
  output logic       data_step,
  output logic       rd_step,
  output logic       active,
  output logic       fl_addr_clk,
  output logic       fl_addr_sdi,
  output logic       fl_data_clk,
  output logic       fl_data_sdi,
  output logic       fl_data_sel,
  output logic       fl_prog,
  output logic       fl_erase
);
  localparam int MAXW = (AW > DW) ? AW : DW;
  localparam int CW   = $clog2(MAXW);

  seq_state_e      state;
  ufm_op_e         op;
  logic            ph;
  logic [CW-1:0]   cnt;
  logic            err;
  logic            hold;

  assign hold       = fl_busy;
  assign abort_evt  = fl_isp_busy && (state != S_IDLE) && (state != S_FIN);
  assign accept_evt = (state == S_IDLE) && cmd_valid;
  assign addr_step  = (state == S_ADDR)  &&  ph && !hold && !abort_evt;
  assign data_step  = (state == S_WDATA) &&  ph && !hold && !abort_evt;
  assign rd_step    = (state == S_RDOUT) && !ph && !hold && !abort_evt;
  assign cmd_ready  = (state == S_IDLE);
  assign rsp_valid  = (state == S_FIN);
  assign rsp_err    = err;
  assign active     = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      op          <= OP_READ;
      ph          <= 1'b0;
      cnt         <= '0;
      err         <= 1'b0;
      fl_addr_clk <= 1'b0;
      fl_addr_sdi <= 1'b0;
      fl_data_clk <= 1'b0;
      fl_data_sdi <= 1'b0;
      fl_data_sel <= 1'b0;
      fl_prog     <= 1'b0;
      fl_erase    <= 1'b0;
    end else begin
      fl_prog  <= 1'b0;
      fl_erase <= 1'b0;
      if (abort_evt) begin
        state       <= S_FIN;
        err         <= 1'b1;
        ph          <= 1'b0;
        cnt         <= '0;
        fl_addr_clk <= 1'b0;
        fl_data_clk <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            fl_addr_clk <= 1'b0;
            fl_data_clk <= 1'b0;
            if (cmd_valid) begin
              if (op_known(cmd_op)) begin
                op    <= ufm_op_e'(cmd_op);
                err   <= 1'b0;
                state <= S_ARM;
              end else begin
                err   <= 1'b1;
                state <= S_FIN;
              end
            end
          end
          S_ARM: begin
            if (!hold) begin
              ph    <= 1'b0;
              cnt   <= '0;
              state <= S_ADDR;
            end
          end
          S_ADDR: begin
            if (!hold) begin
              if (!ph) begin
                fl_addr_clk <= 1'b0;
                fl_addr_sdi <= addr_msb;
                ph          <= 1'b1;
              end else begin
                fl_addr_clk <= 1'b1;
                ph          <= 1'b0;
                if (last_bit(32'(cnt), AW)) begin
                  cnt   <= '0;
                  state <= after_addr(op);
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
            end
          end
          S_LOAD: begin
            if (!hold) begin
              if (!ph) begin
                fl_addr_clk <= 1'b0;
                fl_data_sel <= 1'b0;
                ph          <= 1'b1;
              end else begin
                fl_data_clk <= 1'b1;
                ph          <= 1'b0;
                state       <= S_RDOUT;
              end
            end
          end
          S_RDOUT: begin
            if (!hold) begin
              if (!ph) begin
                fl_data_clk <= 1'b0;
                fl_data_sel <= 1'b1;
                ph          <= 1'b1;
              end else begin
                fl_data_clk <= 1'b1;
                ph          <= 1'b0;
                if (last_bit(32'(cnt), DW)) begin
                  cnt   <= '0;
                  state <= S_FIN;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
            end
          end
          S_WDATA: begin
            if (!hold) begin
              if (!ph) begin
                fl_addr_clk <= 1'b0;
                fl_data_clk <= 1'b0;
                fl_data_sel <= 1'b1;
                fl_data_sdi <= data_msb;
                ph          <= 1'b1;
              end else begin
                fl_data_clk <= 1'b1;
                ph          <= 1'b0;
                if (last_bit(32'(cnt), DW)) begin
                  cnt   <= '0;
                  state <= S_STROBE;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
            end
          end
          S_STROBE: begin
            if (!hold) begin
              fl_addr_clk <= 1'b0;
              fl_data_clk <= 1'b0;
              fl_prog     <= (op == OP_WRITE);
              fl_erase    <= (op == OP_ERASE);
              state       <= S_WAIT_HI;
            end
          end
          S_WAIT_HI: begin
            if (fl_busy) state <= S_WAIT_LO;
          end
          S_WAIT_LO: begin
            if (!fl_busy) state <= S_FIN;
          end
          S_FIN: begin
            fl_addr_clk <= 1'b0;
            fl_data_clk <= 1'b0;
            state       <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ufm_serial_ctrl.sv
module ufm_serial_ctrl
  import ufm_ctrl_pkg::*;
#(
  parameter int AW          = 9,
  parameter int DW          = 16,
  parameter bit OSC_KEEP_ON = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          fl_addr_clk,
  output logic          fl_addr_sdi,
  output logic          fl_data_clk,
  output logic          fl_data_sdi,
  output logic          fl_data_sel,
  input  logic          fl_data_sdo,
  output logic          fl_prog,
  output logic          fl_erase,
  output logic          fl_osc_en,
  input  logic          fl_busy,
  input  logic          fl_isp_busy
);
  logic accept_evt, abort_evt;
  logic addr_step, data_step, rd_step;
  logic addr_msb, data_msb;
  logic seq_active;
  logic rd_clear;

  assign rd_clear = accept_evt || abort_evt;

  ufm_ctrl_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .fl_busy     (fl_busy),
    .fl_isp_busy (fl_isp_busy),
    .addr_msb    (addr_msb),
    .data_msb    (data_msb),
    .cmd_ready   (cmd_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .accept_evt  (accept_evt),
    .abort_evt   (abort_evt),
    .addr_step   (addr_step),
    .data_step   (data_step),
    .rd_step     (rd_step),
    .active      (seq_active),
    .fl_addr_clk (fl_addr_clk),
    .fl_addr_sdi (fl_addr_sdi),
    .fl_data_clk (fl_data_clk),
    .fl_data_sdi (fl_data_sdi),
    .fl_data_sel (fl_data_sel),
    .fl_prog     (fl_prog),
    .fl_erase    (fl_erase)
  );

  ufm_piso #(.W(AW)) u_addr_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .load_val (cmd_addr),
    .step     (addr_step),
    .msb      (addr_msb)
  );

  ufm_piso #(.W(DW)) u_wdata_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_evt),
    .load_val (cmd_wdata),
    .step     (data_step),
    .msb      (data_msb)
  );

  ufm_sipo #(.W(DW)) u_rdata_sr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (rd_clear),
    .step  (rd_step),
    .sin   (fl_data_sdo),
    .q     (rsp_rdata)
  );

  generate
    if (OSC_KEEP_ON) begin : g_osc_on
      assign fl_osc_en = 1'b1;
    end else begin : g_osc_cmd
      assign fl_osc_en = seq_active;
    end
  endgenerate
endmodule

// File: rtl/ufm_ctrl_checker.sv
module ufm_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic fl_addr_clk,
  input logic fl_addr_sdi,
  input logic fl_data_clk,
  input logic fl_data_sdi,
  input logic fl_prog,
  input logic fl_erase,
  input logic fl_busy,
  input logic fl_isp_busy
);
  // R1
  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
  // R1
  a_r1_no_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
  // R2
  a_r2_addr_sdi_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_addr_clk) |-> $stable(fl_addr_sdi));
  // R4
  a_r4_data_sdi_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_data_clk) |-> $stable(fl_data_sdi));
  // R6
  a_r6_no_clock_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fl_busy) |-> !$rose(fl_addr_clk) && !$rose(fl_data_clk));
  // R6
  a_r6_no_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_prog) || $rose(fl_erase) |-> !$past(fl_busy));
  // R7
  a_r7_quiet_in_isp: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fl_isp_busy) |-> !(fl_addr_clk || fl_data_clk || fl_prog || fl_erase));
  // R7
  a_r7_err_on_isp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(fl_isp_busy) |-> rsp_err);
  // R10
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_prog, fl_erase, fl_addr_clk, fl_data_clk}));
  // R10
  a_r10_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
    fl_prog |=> !fl_prog);
  // R10
  a_r10_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |=> !fl_erase);
endmodule

bind ufm_serial_ctrl ufm_ctrl_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .fl_addr_clk (fl_addr_clk),
  .fl_addr_sdi (fl_addr_sdi),
  .fl_data_clk (fl_data_clk),
  .fl_data_sdi (fl_data_sdi),
  .fl_prog     (fl_prog),
  .fl_erase    (fl_erase),
  .fl_busy     (fl_busy),
  .fl_isp_busy (fl_isp_busy)
);

// File: tb/ufm_serial_ctrl_tb.sv
`timescale 1ns/1ps
module ufm_serial_ctrl_tb;
  localparam int AW = 9;
  localparam int DW = 16;
  localparam int NW = 1 << AW;
  localparam int BUSY_CYC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cmd_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic fl_addr_clk, fl_addr_sdi, fl_data_clk, fl_data_sdi, fl_data_sel;
  logic fl_data_sdo, fl_prog, fl_erase, fl_osc_en, fl_busy;
  logic fl_isp_busy = 1'b0;
  logic ext_busy = 1'b0;

  ufm_serial_ctrl #(.AW(AW), .DW(DW), .OSC_KEEP_ON(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .fl_addr_clk(fl_addr_clk), .fl_addr_sdi(fl_addr_sdi),
    .fl_data_clk(fl_data_clk), .fl_data_sdi(fl_data_sdi),
    .fl_data_sel(fl_data_sel), .fl_data_sdo(fl_data_sdo),
    .fl_prog(fl_prog), .fl_erase(fl_erase), .fl_osc_en(fl_osc_en),
    .fl_busy(fl_busy), .fl_isp_busy(fl_isp_busy)
  );

  // ---------------- behavioural flash stand-in ----------------
  logic [DW-1:0] mem [NW];
  logic [AW-1:0] m_areg = '0;
  logic [DW-1:0] m_dreg = '0;
  int            m_busy_cnt = 0;
  int            n_prog = 0, n_erase = 0;

  function automatic logic [DW-1:0] seed_word(input int i);
    return DW'((i * 40503) ^ 16'h5A5A);
  endfunction

  always @(posedge fl_addr_clk) m_areg <= {m_areg[AW-2:0], fl_addr_sdi};
  always @(posedge fl_data_clk) begin
    if (fl_data_sel) m_dreg <= {m_dreg[DW-2:0], fl_data_sdi};
    else             m_dreg <= mem[m_areg];
  end
  assign fl_data_sdo = m_dreg[DW-1];
  assign fl_busy = (m_busy_cnt != 0) || ext_busy;

  always @(posedge clk) begin
    if (m_busy_cnt != 0) m_busy_cnt <= m_busy_cnt - 1;
    if (fl_prog) begin
      mem[m_areg] <= m_dreg;
      m_busy_cnt  <= BUSY_CYC;
      n_prog      <= n_prog + 1;
    end
    if (fl_erase) begin
      for (int i = 0; i < NW; i++)
        if (AW'(i) >> (AW - 1) == {{(AW-1){1'b0}}, m_areg[AW-1]}) mem[i] <= '1;
      m_busy_cnt <= BUSY_CYC;
      n_erase    <= n_erase + 1;
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0, fails = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Interlock observers: values at the previous edge vs after it.
  logic busy_s = 1'b0, isp_s = 1'b0, ac_s = 1'b0, dc_s = 1'b0;
  int busy_viol = 0, isp_viol = 0, busy_rises_seen = 0;
  always @(posedge clk) begin
    busy_s <= fl_busy; isp_s <= fl_isp_busy;
    ac_s <= fl_addr_clk; dc_s <= fl_data_clk;
  end
  always @(negedge clk) if (rst_n) begin
    if (busy_s && ((fl_addr_clk && !ac_s) || (fl_data_clk && !dc_s))) busy_viol++;
    if (ext_busy && busy_s) busy_rises_seen++;
    if (isp_s && (fl_addr_clk || fl_data_clk || fl_prog || fl_erase)) isp_viol++;
  end

  // ---------------- scoreboard ----------------
  logic [DW:0] exp_q [$];
  string       req_q [$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected response", 32'(rsp_err), 32'd0);
      end else begin
        logic [DW:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(rsp_err == e[DW], r, "rsp_err", 32'(rsp_err), 32'(e[DW]));
        chk(rsp_rdata == e[DW-1:0], r, "rsp_rdata", 32'(rsp_rdata), 32'(e[DW-1:0]));
      end
    end
  end

  // Per-command observations made by the driver.
  int  ready_hi_cnt, osc_lo_cnt, done_busy_hi;
  logic saw_busy;

  task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic [DW-1:0] exp_rd,
                         input logic exp_err, input string req);
    exp_q.push_back({exp_err, exp_rd});
    req_q.push_back(req);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    ready_hi_cnt = 0; osc_lo_cnt = 0; done_busy_hi = 0; saw_busy = 1'b0;
    while (!rsp_valid) begin
      if (cmd_ready) ready_hi_cnt++;
      if (!fl_osc_en) osc_lo_cnt++;
      if (fl_busy) saw_busy = 1'b1;
      @(negedge clk);
    end
    if (cmd_ready) ready_hi_cnt++;
    if (!fl_osc_en) osc_lo_cnt++;
    if (fl_busy) done_busy_hi = 1;
    @(negedge clk);
    chk(cmd_ready, "R1", "ready after done", 32'(cmd_ready), 32'd1);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [DW-1:0] keep;
    int p0, e0;
    for (int i = 0; i < NW; i++) mem[i] = seed_word(i);

    // R9: state while reset is held and right after release
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R9", "ready in reset", 32'(cmd_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk({fl_addr_clk, fl_data_clk, fl_prog, fl_erase} == 4'b0, "R9", "pins in reset",
        32'({fl_addr_clk, fl_data_clk, fl_prog, fl_erase}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R9", "ready after reset", 32'({cmd_ready, rsp_valid}), 32'd2);
    chk(fl_osc_en == 1'b0, "R8", "osc off while idle", 32'(fl_osc_en), 32'd0);

    // R3 / R2: reads in both sectors
    run_cmd(2'd0, 9'h005, '0, seed_word(5), 1'b0, "R3");
    chk(ready_hi_cnt == 0, "R1", "ready low during command", 32'(ready_hi_cnt), 32'd0);
    chk(osc_lo_cnt == 0, "R8", "osc on during command", 32'(osc_lo_cnt), 32'd0);
    chk(m_areg == 9'h005, "R2", "address shifted", 32'(m_areg), 32'h005);
    run_cmd(2'd0, 9'h1A3, '0, seed_word(9'h1A3), 1'b0, "R3");
    chk(m_areg == 9'h1A3, "R2", "address shifted", 32'(m_areg), 32'h1A3);

    // R4: writes with two patterns, then read back
    p0 = n_prog;
    run_cmd(2'd1, 9'h123, 16'hBEEF, '0, 1'b0, "R4");
    chk(saw_busy && done_busy_hi == 0, "R4", "done only after busy fell",
        32'({saw_busy, 1'(done_busy_hi)}), 32'd2);
    chk(n_prog == p0 + 1, "R4", "one program strobe", 32'(n_prog), 32'(p0 + 1));
    chk(mem[9'h123] == 16'hBEEF, "R4", "array word", 32'(mem[9'h123]), 32'hBEEF);
    run_cmd(2'd0, 9'h123, '0, 16'hBEEF, 1'b0, "R3");
    run_cmd(2'd1, 9'h000, 16'h0001, '0, 1'b0, "R4");
    run_cmd(2'd0, 9'h000, '0, 16'h0001, 1'b0, "R3");

    // R5: erase upper sector
    e0 = n_erase;
    run_cmd(2'd2, 9'h1C0, '0, '0, 1'b0, "R5");
    chk(saw_busy && done_busy_hi == 0, "R5", "done only after busy fell",
        32'({saw_busy, 1'(done_busy_hi)}), 32'd2);
    chk(n_erase == e0 + 1, "R5", "one erase strobe", 32'(n_erase), 32'(e0 + 1));
    chk(mem[9'h1FF] == 16'hFFFF && mem[9'h100] == 16'hFFFF, "R5", "upper sector erased",
        32'(mem[9'h1FF]), 32'hFFFF);
    chk(mem[9'h005] == seed_word(5), "R5", "lower sector kept", 32'(mem[9'h005]),
        32'(seed_word(5)));
    run_cmd(2'd0, 9'h123, '0, 16'hFFFF, 1'b0, "R5");

    // R6: external busy held in the middle of a read
    fork
      run_cmd(2'd0, 9'h0AA, '0, seed_word(9'h0AA), 1'b0, "R6");
      begin
        repeat (8) @(negedge clk);
        ext_busy = 1'b1;
        repeat (20) @(negedge clk);
        ext_busy = 1'b0;
      end
    join
    chk(busy_rises_seen > 0, "R6", "busy window reached", 32'(busy_rises_seen), 32'd1);
    chk(busy_viol == 0, "R6", "clock rise under busy", 32'(busy_viol), 32'd0);

    // R7: flag already high when the command arrives
    fl_isp_busy = 1'b1;
    run_cmd(2'd0, 9'h005, '0, '0, 1'b1, "R7");
    fl_isp_busy = 1'b0;

    // R7: flag rises during the data shift of a write
    keep = mem[9'h033];
    p0 = n_prog;
    fork
      run_cmd(2'd1, 9'h033, 16'h1234, '0, 1'b1, "R7");
      begin
        repeat (26) @(negedge clk);
        fl_isp_busy = 1'b1;
      end
    join
    repeat (3) @(negedge clk);
    fl_isp_busy = 1'b0;
    chk(n_prog == p0, "R7", "no program strobe", 32'(n_prog), 32'(p0));
    chk(mem[9'h033] == keep, "R7", "array unchanged", 32'(mem[9'h033]), 32'(keep));
    run_cmd(2'd0, 9'h033, '0, keep, 1'b0, "R7");
    chk(isp_viol == 0, "R7", "activity under reprogramming flag", 32'(isp_viol), 32'd0);

    // R11: reserved op code
    p0 = n_prog; e0 = n_erase;
    run_cmd(2'd3, 9'h0F0, 16'hAAAA, '0, 1'b1, "R11");
    chk(m_areg == 9'h033 && n_prog == p0 && n_erase == e0, "R11", "flash untouched",
        32'(m_areg), 32'h033);

    // R10 is also held by the bound checker; confirm scoreboard drained
    chk(exp_q.size() == 0, "R10", "all responses seen", 32'(exp_q.size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule